// File: doc/BRIEF.md
# Dual-Axis Quadrature Decoder with Gated Index Capture

This block turns the A/B phase signals of two incremental encoders into two signed position counts, one per axis. Every edge on A or B moves the count by one step (x4 decoding). The direction of the step depends on which phase leads. Each raw input passes through a synchronizer into the system clock domain before any edge is detected. The count is updated once per clock from the previous and the current synchronized A/B pair. If A and B both change in the same sample, the step is skipped and a sticky error flag is raised.

Each axis also has a holding register that captures its position when a reference event occurs. A per-axis select bit picks the event source, and only the selected source can trigger a capture.

- **Home:** an immediate capture on a falling edge of the active-low home line.
- **Index:** a gated event. The active-low index line must fall first. The capture then fires on whichever A or B transition completes the state where both phases are low. If the index line rises before that happens, the armed condition is dropped.

A capture is presented as a valid/ready output. While `cap_valid` is high, the captured value is held and new reference events are discarded. The handshake (`cap_valid` and `cap_ready` both high on a clock edge) frees the register.

Top module: `qdec_dual`

## Requirements
- R1: Phase code {A,B} stepping 00→10→11→01→00 (A leading B) increments that axis's count by exactly one per transition.
- R2: The opposite order (00→01→11→10→00) decrements by one per transition. Counts below zero read as 32-bit two's complement values.
- R3: A sample in which A and B both differ from the previous sample leaves the count unchanged and sets `err_flag`. The flag stays high until an `err_clr` pulse on that axis.
- R4: With `src_sel`=0, a capture occurs only after `index_n` has gone low. It fires on the transition that brings both A and B low, whichever phase falls last. `cap_pos` then holds the count after that transition.
- R5: If `index_n` returns high before both phases are low, the pending index condition is cancelled. An `index_n` held high never produces a capture.
- R6: With `src_sel`=1, a falling edge on `home_n` captures the current count immediately, whatever the levels of A and B.
- R7: The unselected source never captures. This covers `home_n` edges when `src_sel`=0 and complete index events when `src_sel`=1.
- R8: While `cap_valid` is high and `cap_ready` is low, `cap_valid` and `cap_pos` stay unchanged and further events are ignored. A clock edge with both high clears `cap_valid`.
- R9: The two axes are independent. Inputs of one axis never change the count, capture or error flag of the other.
- R10: After reset every count is 0, and every `cap_valid` and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | NUM_AXES | Raw phase A per axis |
| enc_b | input | NUM_AXES | Raw phase B per axis |
| index_n | input | NUM_AXES | Raw active-low index per axis |
| home_n | input | NUM_AXES | Raw active-low home per axis |
| src_sel | input | NUM_AXES | Capture source per axis: 0 index, 1 home |
| err_clr | input | NUM_AXES | Clears the sticky error flag |
| cap_ready | input | NUM_AXES | Consumer accepts the captured value |
| pos_live | output | NUM_AXES*POS_W | Live counts, axis k at bits k*POS_W upward |
| cap_valid | output | NUM_AXES | Captured value is pending |
| cap_pos | output | NUM_AXES*POS_W | Captured counts, same packing as pos_live |
| err_flag | output | NUM_AXES | Sticky illegal-transition flag |

## Verification
A wrong phase history or direction decode shows up on `pos_live` within a few cycles of the next A/B edge. The count then drifts from the arithmetic expected value by one per step, and the error grows with every further step of a long sweep. A stale or wrongly armed index state shows up on `cap_valid` as a capture in the wrong place or a missing capture. A bad capture path shows up on `cap_pos` as a value off by one from the count after the qualifying edge. Both are visible within the synchronizer latency plus one cycle of the event that completes the condition.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BAD  = 2'd2,
    STEP_REV  = 2'd3
  } step_e;

  // {A,B} -> position in the forward cycle 00,10,11,01
  function automatic logic [1:0] phase_of(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

  function automatic step_e classify(input logic [1:0] ab_prev, input logic [1:0] ab_cur);
    logic [1:0] diff;
    diff = phase_of(ab_cur) - phase_of(ab_prev);
    return step_e'(diff);
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_V;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       ab_s,
  input  logic             err_clr,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_nxt,
  output logic             both_low_edge,
  output logic             err_q
);
  logic [1:0] ab_p;
  step_e      step;

  assign step = classify(ab_p, ab_s);

  always_comb begin
    pos_nxt = pos_q;
    if (en) begin
      case (step)
        STEP_FWD: pos_nxt = pos_q + 1'b1;
        STEP_REV: pos_nxt = pos_q - 1'b1;
        default:  pos_nxt = pos_q;
      endcase
    end
  end

  assign both_low_edge = en && (ab_s == 2'b00) && (ab_p != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_p  <= 2'b00;
      pos_q <= '0;
      err_q <= 1'b0;
    end else begin
      ab_p  <= ab_s;
      pos_q <= pos_nxt;
      if (en && step == STEP_BAD) err_q <= 1'b1;
      else if (err_clr)           err_q <= 1'b0;
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + 1'b1) || (pos_q == $past(pos_q) - 1'b1)); // R1
  AST_BAD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step == STEP_BAD) |=> $stable(pos_q)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R3
endmodule

// File: rtl/qdec_capture.sv
module qdec_capture #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sel_home,
  input  logic             idx_s,
  input  logic             home_s,
  input  logic             both_low_edge,
  input  logic [POS_W-1:0] pos_nxt,
  input  logic             cap_ready,
  output logic             cap_valid,
  output logic [POS_W-1:0] cap_pos
);
  logic idx_p, home_p, armed_q;
  logic idx_fall, home_fire, idx_fire, trig;

  assign idx_fall  = idx_p & ~idx_s;
  assign home_fire = en & home_p & ~home_s;
  assign idx_fire  = en & armed_q & ~idx_s & both_low_edge;
  assign trig      = sel_home ? home_fire : idx_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_p     <= 1'b1;
      home_p    <= 1'b1;
      armed_q   <= 1'b0;
      cap_valid <= 1'b0;
      cap_pos   <= '0;
    end else begin
      idx_p  <= idx_s;
      home_p <= home_s;
      if (!en || idx_s)  armed_q <= 1'b0;
      else if (idx_fall) armed_q <= 1'b1;
      else if (idx_fire) armed_q <= 1'b0;
      if (cap_valid) begin
        if (cap_ready) cap_valid <= 1'b0;
      end else if (trig) begin
        cap_valid <= 1'b1;
        cap_pos   <= pos_nxt;
      end
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> (cap_valid && $stable(cap_pos))); // R8
  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    idx_s |=> !armed_q); // R5
endmodule

// File: rtl/qdec_axis.sv
module qdec_axis #(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_raw,
  input  logic             b_raw,
  input  logic             idx_raw,
  input  logic             home_raw,
  input  logic             sel_home,
  input  logic             err_clr,
  input  logic             cap_ready,
  output logic [POS_W-1:0] pos,
  output logic             cap_valid,
  output logic [POS_W-1:0] cap_pos,
  output logic             err
);
  localparam int WARM    = SYNC_STAGES + 1;
  localparam int WW      = $clog2(WARM + 1);
  localparam logic [WW-1:0] WARM_V = WW'(WARM);

  logic [1:0]       ab_s, ref_s;
  logic [WW-1:0]    warm_q;
  logic             en;
  logic [POS_W-1:0] pos_nxt;
  logic             low_edge;

  qdec_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(2'b00)) u_sync_ab (
    .clk(clk), .rst_n(rst_n), .d({a_raw, b_raw}), .q(ab_s));
  qdec_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(2'b11)) u_sync_ref (
    .clk(clk), .rst_n(rst_n), .d({idx_raw, home_raw}), .q(ref_s));

  always_ff @(posedge clk) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != WARM_V) warm_q <= warm_q + 1'b1;
  end
  assign en = (warm_q == WARM_V);

  qdec_decode #(.POS_W(POS_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .en(en), .ab_s(ab_s), .err_clr(err_clr),
    .pos_q(pos), .pos_nxt(pos_nxt), .both_low_edge(low_edge), .err_q(err));

  qdec_capture #(.POS_W(POS_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .en(en), .sel_home(sel_home),
    .idx_s(ref_s[1]), .home_s(ref_s[0]), .both_low_edge(low_edge),
    .pos_nxt(pos_nxt), .cap_ready(cap_ready),
    .cap_valid(cap_valid), .cap_pos(cap_pos));
endmodule

// File: rtl/qdec_dual.sv
module qdec_dual #(
  parameter int NUM_AXES    = 2,
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_AXES-1:0]       enc_a,
  input  logic [NUM_AXES-1:0]       enc_b,
  input  logic [NUM_AXES-1:0]       index_n,
  input  logic [NUM_AXES-1:0]       home_n,
  input  logic [NUM_AXES-1:0]       src_sel,
  input  logic [NUM_AXES-1:0]       err_clr,
  input  logic [NUM_AXES-1:0]       cap_ready,
  output logic [NUM_AXES*POS_W-1:0] pos_live,
  output logic [NUM_AXES-1:0]       cap_valid,
  output logic [NUM_AXES*POS_W-1:0] cap_pos,
  output logic [NUM_AXES-1:0]       err_flag
);
  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    qdec_axis #(.POS_W(POS_W), .SYNC_STAGES(SYNC_STAGES)) u_axis (
      .clk(clk), .rst_n(rst_n),
      .a_raw(enc_a[k]), .b_raw(enc_b[k]),
      .idx_raw(index_n[k]), .home_raw(home_n[k]),
      .sel_home(src_sel[k]), .err_clr(err_clr[k]), .cap_ready(cap_ready[k]),
      .pos(pos_live[k*POS_W +: POS_W]),
      .cap_valid(cap_valid[k]),
      .cap_pos(cap_pos[k*POS_W +: POS_W]),
      .err(err_flag[k]));
  end
endmodule

// File: tb/qdec_dual_tb.sv
module qdec_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  enc_a = '0, enc_b = '0, index_n = '1, home_n = '1;
  logic [1:0]  src_sel = '0, err_clr = '0, cap_ready = '0;
  logic [63:0] pos_live, cap_pos;
  logic [1:0]  cap_valid, err_flag;

  int checks = 0, errors = 0;
  logic [1:0]  ph   [2];
  logic [31:0] mpos [2];
  logic [31:0] held;

  always #5 clk = ~clk;

  qdec_dual dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .index_n(index_n), .home_n(home_n), .src_sel(src_sel),
    .err_clr(err_clr), .cap_ready(cap_ready), .pos_live(pos_live),
    .cap_valid(cap_valid), .cap_pos(cap_pos), .err_flag(err_flag));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  // phase 0..3 -> {A,B} = 00,10,11,01
  task automatic drive(input int ax);
    enc_a[ax] = (ph[ax] == 2'd1) || (ph[ax] == 2'd2);
    enc_b[ax] = (ph[ax] == 2'd2) || (ph[ax] == 2'd3);
    settle();
  endtask

  task automatic step(input int ax, input bit fwd);
    ph[ax]   = fwd ? ph[ax] + 2'd1 : ph[ax] - 2'd1;
    mpos[ax] = fwd ? mpos[ax] + 32'd1 : mpos[ax] - 32'd1;
    drive(ax);
  endtask

  task automatic go_phase(input int ax, input logic [1:0] p);
    while (ph[ax] != p) step(ax, 1'b1);
  endtask

  task automatic ack(input int ax);
    cap_ready[ax] = 1'b1;
    @(negedge clk);
    cap_ready[ax] = 1'b0;
    settle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ph[0] = 0; ph[1] = 0; mpos[0] = 0; mpos[1] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R10 reset state
    chk("R10", pos_live[31:0], 0);
    chk("R10", pos_live[63:32], 0);
    chk("R10", {30'd0, cap_valid}, 0);
    chk("R10", {30'd0, err_flag}, 0);

    // R1 forward sweep, index held high
    for (int i = 0; i < 40; i++) begin
      step(0, 1'b1);
      chk("R1", pos_live[31:0], mpos[0]);
    end
    chk("R5", {31'd0, cap_valid[0]}, 0);   // index high: never captures
    chk("R9", pos_live[63:32], 0);

    // R2 reverse sweep into negative values
    for (int i = 0; i < 60; i++) begin
      step(0, 1'b0);
      chk("R2", pos_live[31:0], mpos[0]);
    end
    chk("R2", pos_live[31:0], 32'hFFFF_FFEC);

    // R3 illegal jumps from every phase
    for (int i = 0; i < 4; i++) begin
      ph[0] = ph[0] + 2'd2;
      drive(0);
      chk("R3", pos_live[31:0], mpos[0]);
      chk("R3", {31'd0, err_flag[0]}, 1);
      settle();
      chk("R3", {31'd0, err_flag[0]}, 1);
      err_clr[0] = 1'b1; @(negedge clk); err_clr[0] = 1'b0; settle();
      chk("R3", {31'd0, err_flag[0]}, 0);
    end
    chk("R9", {31'd0, err_flag[1]}, 0);

    // R4 index capture, B falls last
    go_phase(0, 2'd2);
    index_n[0] = 1'b0; settle();
    step(0, 1'b1);
    chk("R4", {31'd0, cap_valid[0]}, 0);
    step(0, 1'b1);
    chk("R4", {31'd0, cap_valid[0]}, 1);
    chk("R4", cap_pos[31:0], mpos[0]);
    held = mpos[0];

    // R8 further events dropped while pending
    index_n[0] = 1'b1; settle();
    go_phase(0, 2'd2);
    index_n[0] = 1'b0; settle();
    step(0, 1'b1); step(0, 1'b1);
    chk("R8", {31'd0, cap_valid[0]}, 1);
    chk("R8", cap_pos[31:0], held);
    ack(0);
    chk("R8", {31'd0, cap_valid[0]}, 0);

    // R4 index capture, A falls last (reverse direction)
    index_n[0] = 1'b1; settle();
    go_phase(0, 2'd2);
    index_n[0] = 1'b0; settle();
    step(0, 1'b0);
    chk("R4", {31'd0, cap_valid[0]}, 0);
    step(0, 1'b0);
    chk("R4", {31'd0, cap_valid[0]}, 1);
    chk("R4", cap_pos[31:0], mpos[0]);
    ack(0);

    // R5 index rises between the two phase falls
    index_n[0] = 1'b1; settle();
    go_phase(0, 2'd2);
    index_n[0] = 1'b0; settle();
    step(0, 1'b1);
    index_n[0] = 1'b1; settle();
    step(0, 1'b1);
    chk("R5", {31'd0, cap_valid[0]}, 0);

    // R7 home ignored while index selected
    home_n[0] = 1'b0; settle();
    chk("R7", {31'd0, cap_valid[0]}, 0);
    home_n[0] = 1'b1; settle();

    // R6 home capture with A high, B low
    src_sel[0] = 1'b1;
    go_phase(0, 2'd1);
    home_n[0] = 1'b0; settle();
    chk("R6", {31'd0, cap_valid[0]}, 1);
    chk("R6", cap_pos[31:0], mpos[0]);
    ack(0);
    home_n[0] = 1'b1; settle();

    // R7 complete index event ignored while home selected
    go_phase(0, 2'd2);
    index_n[0] = 1'b0; settle();
    step(0, 1'b1); step(0, 1'b1);
    chk("R7", {31'd0, cap_valid[0]}, 0);
    index_n[0] = 1'b1; settle();

    // R9 axis 1 on its own
    src_sel[1] = 1'b1;
    for (int i = 0; i < 3; i++) step(1, 1'b1);
    chk("R9", pos_live[63:32], 3);
    chk("R9", pos_live[31:0], mpos[0]);
    home_n[1] = 1'b0; settle();
    chk("R9", {31'd0, cap_valid[1]}, 1);
    chk("R9", cap_pos[63:32], 3);
    chk("R9", {31'd0, cap_valid[0]}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule